// File: doc/BRIEF.md
# Command Stream Word Parser

This block accepts 32-bit words from a command stream over a valid/ready handshake. It decides for each word whether the word opens a new command or is a trailing word of the command before it. A header is split into its opcode and fields. From these the parser works out how many trailing words come next, and it emits one decoded record per accepted word. Register-write commands have their trailing data words tagged with the register offset that each word targets. Gather commands have their trailing words marked as addresses. Lock requests and malformed commands appear as flags on the header record.

A 32-bit payload register is loaded by the set-payload command. It supplies the length of the wide-offset write commands. Reset puts this register into an all-ones invalid state. The parser performs no memory fetch and no lock arbitration. It only reports these as decoded events to the logic downstream.

Top module: `cmd_word_parser`

## Requirements
- R1: A word is a header only when the remaining-word counter is zero. The opcode sits in bits 31:28. A header loads the counter with its trailing-word count, and each accepted data word lowers the counter by one. On a data record, `out_count` gives the number of data words still to come after that word.
- R2: Opcodes 0 and 3 use a mask: opcode 0 takes a 6-bit mask from bits 5:0 and opcode 3 takes a 16-bit mask from bits 15:0. The trailing count equals the number of set bits in the mask. Both opcodes report the offset from bits 27:16, and opcode 0 also reports the class id from bits 15:6 in `out_val`.
- R3: Opcodes 1 (incrementing) and 2 (fixed) report the offset from bits 27:16 and take the trailing count from bits 15:0. A count of zero means no data words follow.
- R4: Opcode 6 reports the offset from bits 27:16, an insert flag from bit 15, a type flag from bit 14 and a count from bits 13:0. One address word follows it. Opcode 12 reports a count from bits 13:0 and is followed by two address words. Address words carry `out_addr`=1, and their offset tag is the header offset (zero for opcode 12).
- R5: Opcode 9 loads bits 15:0 into the payload register and reports that value. Opcodes 10 (incrementing) and 11 (fixed) report a 22-bit offset from bits 21:0 and take a trailing count equal to the payload. A payload of zero gives no data words.
- R6: Reset sets the payload register to all ones, which marks it invalid. An opcode 10 or 11 seen while the payload is invalid sets `out_unk_len` and consumes no data words.
- R7: Opcode 14 takes a sub-opcode from bits 27:24 and an index from bits 7:0. Sub-opcode 0 sets `out_lock_acq` and sub-opcode 1 sets `out_lock_rel`, and `out_val` carries the index in both cases. Any other sub-opcode, and opcode 15, sets `out_unk_cmd`, puts the whole word in `out_val` and gives zero trailing words.
- R8: Data words of incrementing writes are tagged with the header offset plus their position in the burst (0, 1, 2, ...). Data words of fixed writes all carry the header offset.
- R9: Data words of mask commands are tagged with the header offset plus the index of the next set mask bit, taken from bit 0 upward.
- R10: Opcode 4 reports the offset from bits 27:16 and bits 15:0 in `out_val`. Opcodes 5 and 13 report bits 27:0 shifted left by 4. Opcode 7 reports bits 21:0 and opcode 8 reports bits 7:0. None of these opcodes has trailing words.
- R11: `in_ready` is high when no record is held or `out_ready` is high. While a record waits with `out_ready` low, the record stays unchanged.
- R12: A record appears on the output one cycle after its word is accepted. Synchronous reset clears `out_valid` and the counter, and it drops any command still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Parser can take a word |
| in_data | input | 32 | Command stream word |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_is_hdr | output | 1 | Record is a header |
| out_opcode | output | 4 | Opcode of the header or of the owning header |
| out_offset | output | 22 | Header offset, or target offset of a data word |
| out_val | output | 32 | Decoded value field, or the data word itself |
| out_mask | output | 16 | Mask of a mask header |
| out_count | output | 16 | Trailing words still to follow |
| out_addr | output | 1 | Data word is a gather address |
| out_insert | output | 1 | Gather insert flag |
| out_type | output | 1 | Gather type flag |
| out_unk_len | output | 1 | Wide write with invalid payload |
| out_unk_cmd | output | 1 | Undefined opcode or sub-opcode |
| out_lock_acq | output | 1 | Lock acquire request |
| out_lock_rel | output | 1 | Lock release request |

## Verification
Each record is due exactly one clock edge after the edge that accepts its word. The bench therefore drives each word on a falling edge and checks the record for that word on the next falling edge, at the same moment it drives the following word. The payload register and the counter have no output of their own. Their effects appear in a later record: for example, a header that arrives right after a reset, or the trailing count of a wide write that follows a set-payload. The bench checks these at the same one-cycle point. During backpressure the record must not change on any cycle while `out_ready` is low, so the bench samples it on each of those cycles.

// File: rtl/cmd_word_parser.sv
module cmd_word_parser #(
  parameter int OFF_W = 22,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_is_hdr,
  output logic [3:0]       out_opcode,
  output logic [OFF_W-1:0] out_offset,
  output logic [31:0]      out_val,
  output logic [15:0]      out_mask,
  output logic [CNT_W-1:0] out_count,
  output logic             out_addr,
  output logic             out_insert,
  output logic             out_type,
  output logic             out_unk_len,
  output logic             out_unk_cmd,
  output logic             out_lock_acq,
  output logic             out_lock_rel
);

  localparam logic [31:0] PL_INVALID = 32'hFFFF_FFFF;
  localparam logic [1:0]  MD_FIX = 2'd0, MD_INC = 2'd1, MD_MSK = 2'd2, MD_ADR = 2'd3;

  function automatic logic [CNT_W-1:0] pop16(input logic [15:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < 16; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  logic [CNT_W-1:0] remain;
  logic [1:0]       mode;
  logic [3:0]       cur_op;
  logic [OFF_W-1:0] cur_off;
  logic [15:0]      mask_rem;
  logic [31:0]      payload;

  logic fire, hdr_now, pl_bad;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign hdr_now  = (remain == '0);
  assign pl_bad   = (payload == PL_INVALID);

  logic [3:0]       op;
  logic [OFF_W-1:0] off12, off22;
  assign op    = in_data[31:28];
  assign off12 = OFF_W'(in_data[27:16]);
  assign off22 = OFF_W'(in_data[21:0]);

  logic [CNT_W-1:0] d_cnt;
  logic [OFF_W-1:0] d_off;
  logic [31:0]      d_val;
  logic [15:0]      d_mask;
  logic [1:0]       d_mode;
  logic             d_ins, d_typ, d_ulen, d_ucmd, d_acq, d_rel;

  always_comb begin
    d_cnt = '0; d_off = '0; d_val = '0; d_mask = '0; d_mode = MD_FIX;
    d_ins = 1'b0; d_typ = 1'b0; d_ulen = 1'b0; d_ucmd = 1'b0; d_acq = 1'b0; d_rel = 1'b0;
    case (op)
      4'h0: begin
        d_off = off12; d_val = {22'b0, in_data[15:6]};
        d_mask = {10'b0, in_data[5:0]}; d_cnt = pop16(d_mask); d_mode = MD_MSK;
      end
      4'h1: begin d_off = off12; d_cnt = CNT_W'(in_data[15:0]); d_mode = MD_INC; end
      4'h2: begin d_off = off12; d_cnt = CNT_W'(in_data[15:0]); d_mode = MD_FIX; end
      4'h3: begin
        d_off = off12; d_mask = in_data[15:0]; d_cnt = pop16(d_mask); d_mode = MD_MSK;
      end
      4'h4: begin d_off = off12; d_val = {16'b0, in_data[15:0]}; end
      4'h5, 4'hD: d_val = {in_data[27:0], 4'b0};
      4'h6: begin
        d_off = off12; d_val = {18'b0, in_data[13:0]};
        d_ins = in_data[15]; d_typ = in_data[14]; d_cnt = CNT_W'(1); d_mode = MD_ADR;
      end
      4'h7: d_val = {10'b0, in_data[21:0]};
      4'h8: d_val = {24'b0, in_data[7:0]};
      4'h9: d_val = {16'b0, in_data[15:0]};
      4'hA, 4'hB: begin
        d_off  = off22;
        d_mode = (op == 4'hA) ? MD_INC : MD_FIX;
        if (pl_bad) d_ulen = 1'b1;
        else        d_cnt  = CNT_W'(payload[15:0]);
      end
      4'hC: begin d_val = {18'b0, in_data[13:0]}; d_cnt = CNT_W'(2); d_mode = MD_ADR; end
      4'hE: begin
        if (in_data[27:24] == 4'h0) begin d_acq = 1'b1; d_val = {24'b0, in_data[7:0]}; end
        else if (in_data[27:24] == 4'h1) begin d_rel = 1'b1; d_val = {24'b0, in_data[7:0]}; end
        else begin d_ucmd = 1'b1; d_val = in_data; end
      end
      default: begin d_ucmd = 1'b1; d_val = in_data; end
    endcase
  end

  logic [3:0]       lo_idx;
  logic [OFF_W-1:0] data_off;
  always_comb begin
    lo_idx = '0;
    for (int i = 15; i >= 0; i--) if (mask_rem[i]) lo_idx = 4'(i);
  end
  assign data_off = (mode == MD_MSK) ? cur_off + OFF_W'(lo_idx) : cur_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      mode     <= MD_FIX;
      cur_op   <= '0;
      cur_off  <= '0;
      mask_rem <= '0;
      payload  <= PL_INVALID;
    end else if (fire) begin
      if (hdr_now) begin
        remain   <= d_cnt;
        mode     <= d_mode;
        cur_op   <= op;
        cur_off  <= d_off;
        mask_rem <= d_mask;
        if (op == 4'h9) payload <= {16'b0, in_data[15:0]};
      end else begin
        remain <= remain - CNT_W'(1);
        if (mode == MD_INC) cur_off <= cur_off + OFF_W'(1);
        if (mode == MD_MSK) mask_rem[lo_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_is_hdr <= 1'b0; out_opcode <= '0; out_offset <= '0; out_val <= '0;
      out_mask <= '0; out_count <= '0; out_addr <= 1'b0; out_insert <= 1'b0;
      out_type <= 1'b0; out_unk_len <= 1'b0; out_unk_cmd <= 1'b0;
      out_lock_acq <= 1'b0; out_lock_rel <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      if (hdr_now) begin
        out_is_hdr <= 1'b1; out_opcode <= op; out_offset <= d_off; out_val <= d_val;
        out_mask <= d_mask; out_count <= d_cnt; out_addr <= 1'b0; out_insert <= d_ins;
        out_type <= d_typ; out_unk_len <= d_ulen; out_unk_cmd <= d_ucmd;
        out_lock_acq <= d_acq; out_lock_rel <= d_rel;
      end else begin
        out_is_hdr <= 1'b0; out_opcode <= cur_op; out_offset <= data_off; out_val <= in_data;
        out_mask <= '0; out_count <= remain - CNT_W'(1); out_addr <= (mode == MD_ADR);
        out_insert <= 1'b0; out_type <= 1'b0; out_unk_len <= 1'b0; out_unk_cmd <= 1'b0;
        out_lock_acq <= 1'b0; out_lock_rel <= 1'b0;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HDR_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fire && remain == '0) |=> (out_valid && out_is_hdr)); // R1
  AST_DATA_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (fire && remain != '0) |=> (!out_is_hdr && remain == $past(remain) - CNT_W'(1))); // R1
  AST_UNKNOWN_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_hdr && (out_unk_cmd || out_unk_len)) |-> (out_count == '0 && remain == '0)); // R7
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({out_lock_acq, out_lock_rel, out_unk_cmd})); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_val) && $stable(out_offset) && $stable(out_is_hdr))); // R11
  AST_ADDR_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_addr) |-> (!out_is_hdr && (out_opcode == 4'h6 || out_opcode == 4'hC))); // R4

endmodule

// File: tb/cmd_word_parser_tb.sv
module cmd_word_parser_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_is_hdr, out_addr, out_insert, out_type;
  logic out_unk_len, out_unk_cmd, out_lock_acq, out_lock_rel;
  logic [3:0] out_opcode;
  logic [21:0] out_offset;
  logic [31:0] out_val;
  logic [15:0] out_mask, out_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_word_parser dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_hdr(out_is_hdr),
    .out_opcode(out_opcode), .out_offset(out_offset), .out_val(out_val),
    .out_mask(out_mask), .out_count(out_count), .out_addr(out_addr),
    .out_insert(out_insert), .out_type(out_type), .out_unk_len(out_unk_len),
    .out_unk_cmd(out_unk_cmd), .out_lock_acq(out_lock_acq), .out_lock_rel(out_lock_rel)
  );

  typedef struct packed {
    logic [31:0] w;
    logic        hdr;
    logic [21:0] off;
    logic [31:0] v;
    logic [15:0] cnt;
    logic [15:0] m;
    logic [6:0]  fl;   // addr, insert, type, unk_len, unk_cmd, acq, rel
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{32'hA0000123, 1'b1, 22'h123, 32'h0, 16'd0, 16'h0, 7'b0001000},          // R6 invalid payload
    '{32'h0030154A, 1'b1, 22'h030, 32'h55, 16'd2, 16'h000A, 7'b0},            // R2 6-bit mask
    '{32'h11111111, 1'b0, 22'h031, 32'h11111111, 16'd1, 16'h0, 7'b0},         // R9
    '{32'h22222222, 1'b0, 22'h033, 32'h22222222, 16'd0, 16'h0, 7'b0},         // R9
    '{32'h11000003, 1'b1, 22'h100, 32'h0, 16'd3, 16'h0, 7'b0},                // R3
    '{32'hA0000001, 1'b0, 22'h100, 32'hA0000001, 16'd2, 16'h0, 7'b0},         // R8 R1
    '{32'hA0000002, 1'b0, 22'h101, 32'hA0000002, 16'd1, 16'h0, 7'b0},         // R8
    '{32'hA0000003, 1'b0, 22'h102, 32'hA0000003, 16'd0, 16'h0, 7'b0},         // R8
    '{32'h22000002, 1'b1, 22'h200, 32'h0, 16'd2, 16'h0, 7'b0},                // R3
    '{32'hB0000001, 1'b0, 22'h200, 32'hB0000001, 16'd1, 16'h0, 7'b0},         // R8
    '{32'hB0000002, 1'b0, 22'h200, 32'hB0000002, 16'd0, 16'h0, 7'b0},         // R8
    '{32'h30108001, 1'b1, 22'h010, 32'h0, 16'd2, 16'h8001, 7'b0},             // R2 16-bit mask
    '{32'hC0000001, 1'b0, 22'h010, 32'hC0000001, 16'd1, 16'h0, 7'b0},         // R9
    '{32'hC0000002, 1'b0, 22'h01F, 32'hC0000002, 16'd0, 16'h0, 7'b0},         // R9
    '{32'h4044BEEF, 1'b1, 22'h044, 32'hBEEF, 16'd0, 16'h0, 7'b0},             // R10
    '{32'h50001234, 1'b1, 22'h0, 32'h00012340, 16'd0, 16'h0, 7'b0},           // R10
    '{32'h60AB8123, 1'b1, 22'h0AB, 32'h123, 16'd1, 16'h0, 7'b0100000},        // R4
    '{32'hDEAD0000, 1'b0, 22'h0AB, 32'hDEAD0000, 16'd0, 16'h0, 7'b1000000},   // R4
    '{32'h70123456, 1'b1, 22'h0, 32'h123456, 16'd0, 16'h0, 7'b0},             // R10
    '{32'h800000C3, 1'b1, 22'h0, 32'hC3, 16'd0, 16'h0, 7'b0},                 // R10
    '{32'h90000002, 1'b1, 22'h0, 32'h2, 16'd0, 16'h0, 7'b0},                  // R5
    '{32'hA03ABCDE, 1'b1, 22'h3ABCDE, 32'h0, 16'd2, 16'h0, 7'b0},             // R5
    '{32'hD0000001, 1'b0, 22'h3ABCDE, 32'hD0000001, 16'd1, 16'h0, 7'b0},      // R8
    '{32'hD0000002, 1'b0, 22'h3ABCDF, 32'hD0000002, 16'd0, 16'h0, 7'b0},      // R8
    '{32'hB0000040, 1'b1, 22'h040, 32'h0, 16'd2, 16'h0, 7'b0},                // R5
    '{32'hE0000001, 1'b0, 22'h040, 32'hE0000001, 16'd1, 16'h0, 7'b0},         // R8
    '{32'hE0000002, 1'b0, 22'h040, 32'hE0000002, 16'd0, 16'h0, 7'b0},         // R8
    '{32'hC0000010, 1'b1, 22'h0, 32'h10, 16'd2, 16'h0, 7'b0},                 // R4
    '{32'hF0000001, 1'b0, 22'h0, 32'hF0000001, 16'd1, 16'h0, 7'b1000000},     // R4
    '{32'hF0000002, 1'b0, 22'h0, 32'hF0000002, 16'd0, 16'h0, 7'b1000000},     // R4
    '{32'hE0000005, 1'b1, 22'h0, 32'h5, 16'd0, 16'h0, 7'b0000010},            // R7 acquire
    '{32'hE1000007, 1'b1, 22'h0, 32'h7, 16'd0, 16'h0, 7'b0000001},            // R7 release
    '{32'hE3000001, 1'b1, 22'h0, 32'hE3000001, 16'd0, 16'h0, 7'b0000100},     // R7 bad sub-op
    '{32'hF0000000, 1'b1, 22'h0, 32'hF0000000, 16'd0, 16'h0, 7'b0000100},     // R7 opcode 15
    '{32'h90000000, 1'b1, 22'h0, 32'h0, 16'd0, 16'h0, 7'b0},                  // R5
    '{32'hA0000005, 1'b1, 22'h005, 32'h0, 16'd0, 16'h0, 7'b0},                // R5 zero payload
    '{32'h10050000, 1'b1, 22'h005, 32'h0, 16'd0, 16'h0, 7'b0},                // R3 zero count
    '{32'h00000040, 1'b1, 22'h0, 32'h1, 16'd0, 16'h0, 7'b0},                  // R2 zero mask
    '{32'h40000001, 1'b1, 22'h0, 32'h1, 16'd0, 16'h0, 7'b0},                  // R1
    '{32'h60004002, 1'b1, 22'h0, 32'h2, 16'd1, 16'h0, 7'b0010000},            // R4 type flag
    '{32'h12345678, 1'b0, 22'h0, 32'h12345678, 16'd0, 16'h0, 7'b1000000},     // R4
    '{32'hD0001234, 1'b1, 22'h0, 32'h00012340, 16'd0, 16'h0, 7'b0},           // R10
    '{32'h0FFF003F, 1'b1, 22'hFFF, 32'h0, 16'd6, 16'h003F, 7'b0},             // R2 full 6-bit mask
    '{32'h55555555, 1'b0, 22'hFFF, 32'h55555555, 16'd5, 16'h0, 7'b0}          // R9
  };

  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic [95:0] rec();
    return {out_is_hdr, out_offset, out_val, out_count, out_mask,
            {out_addr, out_insert, out_type, out_unk_len, out_unk_cmd, out_lock_acq, out_lock_rel}};
  endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 reset out_valid/in_ready", {94'b0, out_valid, in_ready}, {94'b0, 1'b0, 1'b1});

    // table walk: each record is checked one cycle after its word
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk($sformatf("R1..R10 vector %0d", i-1), rec(),
            {VECS[i-1].hdr, VECS[i-1].off, VECS[i-1].v, VECS[i-1].cnt, VECS[i-1].m, VECS[i-1].fl});
        chk("R12 valid one cycle after accept", {95'b0, out_valid}, {95'b0, 1'b1});
      end
      in_valid = 1'b1;
      in_data  = VECS[i].w;
    end
    @(negedge clk);
    chk("R1..R10 last vector", rec(),
        {VECS[NV-1].hdr, VECS[NV-1].off, VECS[NV-1].v, VECS[NV-1].cnt, VECS[NV-1].m, VECS[NV-1].fl});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R12 idle after stream", {95'b0, out_valid}, {95'b0, 1'b0});

    // remaining 5 data words of the full-mask header would follow; drop them with reset
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11 backpressure
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 32'h13000001;
    @(negedge clk);
    chk("R11 header held", rec(), {1'b1, 22'h300, 32'h0, 16'd1, 16'h0, 7'b0});
    in_data = 32'h00000055;
    chk("R11 in_ready low while stalled", {95'b0, in_ready}, {95'b0, 1'b0});
    @(negedge clk);
    chk("R11 record stable under stall", rec(), {1'b1, 22'h300, 32'h0, 16'd1, 16'h0, 7'b0});
    out_ready = 1'b1;
    @(negedge clk);
    chk("R11 data after release", rec(), {1'b0, 22'h300, 32'h55, 16'd0, 16'h0, 7'b0});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R12 record drained", {95'b0, out_valid}, {95'b0, 1'b0});

    // R12 / R6: reset mid-command drops the burst and invalidates the payload
    send(32'h90000003);
    send(32'hA0000100);
    send(32'h00000AAA);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 burst first word before reset", rec(), {1'b0, 22'h100, 32'hAAA, 16'd2, 16'h0, 7'b0});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send(32'h40000007);
    @(negedge clk);
    in_data = 32'hA0000010;
    chk("R12 word after reset is header", rec(), {1'b1, 22'h0, 32'h7, 16'd0, 16'h0, 7'b0});
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 payload invalid again after reset", rec(), {1'b1, 22'h010, 32'h0, 16'd0, 16'h0, 7'b0001000});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule